// File: doc/BRIEF.md
# DRAM-Port Cycle Decoder with Per-Bit Write Mask

This block is the control logic for the random-access port of a dual-port video memory. The strobes are sampled on a system clock. On the clock edge where the row strobe is first seen low, the block reads the other control inputs and picks the kind of cycle. The possible kinds are a plain read/write access, a masked write, a transfer, a strobe-order refresh, or a reserved special-function cycle. That same edge also latches the row address. While the row strobe stays high, none of the other inputs has any effect.

During an access or masked cycle, every column-strobe fall latches a column address. A write is an early write when write-enable is already low at the column fall, and a late write when write-enable falls while the column strobe is held low. Each write leaves the block as a single-clock pulse to the storage array. The pulse carries the word address, the data and per-bit enables. In a masked cycle, the data pins are captured at the row fall as a write mask. That mask gates every column written in the cycle and is cleared when the row strobe returns high. Reads drive the data outputs only while the column strobe and the output-enable input are both low.

Top module: `dram_cycle_ctl`

## Requirements
- R1: Out of reset, `cyc_kind` is 0 (idle), `mask_q` is 0, and both `mem_we` and `dq_oe` are 0.
- R2: While `ras_n` is high, activity on `cas_n`, `wme_n`, `xoe_n`, `fsel`, `addr` and `dq_in` leaves `cyc_kind` at 0 and `mem_we` and `dq_oe` at 0.
- R3: On the clock edge where `ras_n` is first sampled low, the cycle kind is chosen in this priority order, and `cyc_kind` shows it from the following clock:
  - `cas_n` low gives refresh (4).
  - Otherwise, `xoe_n` low gives transfer (3).
  - Otherwise, `wme_n` low with `fsel` low gives masked write (2).
  - Otherwise, `wme_n` low with `fsel` high gives special (5).
  - Otherwise the cycle is an access (1).
  - The clock after an edge that samples `ras_n` high, `cyc_kind` is back at 0.
- R4: The row address is latched at the row fall and a column address at each column fall. `word_addr` is {row, column}, with the row in the upper `A_W` bits.
- R5: In a masked cycle, `mask_q` holds the `dq_in` value sampled at the row fall.
- R6: Each write pulse carries per-bit enables. In a masked cycle, `mem_wbe` equals `mask_q`, so an enable of 1 writes that bit and 0 leaves the stored bit unchanged. In an access cycle, `mem_wbe` is all ones.
- R7: `mask_q` returns to 0 the clock after `ras_n` is sampled high, so each masked cycle needs a fresh load.
- R8: The same mask gates every column written within one row cycle (page mode).
- R9: When `wme_n` is low at the column fall, `mem_we` is high for exactly the next clock. During that clock `mem_wdata` equals the `dq_in` value from that edge and `late_wr` is 0.
- R10: When `wme_n` falls while `cas_n` is held low, `mem_we` is high for one clock with `late_wr` 1. At most one write occurs per column-low period.
- R11: During a read, `dq_oe` goes high the clock after an edge that samples `ras_n`, `cas_n` and `xoe_n` all low in an access or masked cycle with no write in that column period. While `dq_oe` is high, `dq_out` equals `mem_rdata`.
- R12: Refresh, transfer and special cycles never raise `mem_we` or `dq_oe`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; all strobes are sampled on its rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| ras_n | input | 1 | Row strobe, active low; acts as master enable |
| cas_n | input | 1 | Column strobe, active low |
| xoe_n | input | 1 | Transfer select at row fall, output enable afterwards |
| wme_n | input | 1 | Mask select at row fall, write enable afterwards |
| fsel | input | 1 | Special-function select sampled at row fall |
| addr | input | A_W | Multiplexed row/column address |
| dq_in | input | D_W | Data pins in; mask value at a masked row fall |
| mem_rdata | input | D_W | Read data from the storage array at `word_addr` |
| cyc_kind | output | 3 | Current cycle kind (encoding in R3) |
| word_addr | output | 2*A_W | {row, column} word address |
| mask_q | output | D_W | Current write-mask register |
| mem_we | output | 1 | One-clock write pulse to the array |
| mem_wbe | output | D_W | Per-bit write enables for the pulse |
| mem_wdata | output | D_W | Write data for the pulse |
| late_wr | output | 1 | 1 when the last write pulse came from a late write |
| dq_oe | output | 1 | Read data output enable |
| dq_out | output | D_W | Read data; 0 when `dq_oe` is low |

## Verification
Every cycle kind is opened at least once in a directed pass. The kinds differ only in the pins held at the row fall, so a wrong decode priority shows up as a wrong `cyc_kind` value. Early and late writes are applied to the same and to different addresses and then read back. This separates the timing of the write-enable fall from the data that is captured. Masked page-mode cycles write several columns under one mask, and the next cycle loads a different mask. This exposes a mask that is not applied, not held across columns, or not cleared. A seeded random run mixes all kinds, masks and write styles over a small address window, so that masked merges land on words already written.

// File: rtl/dcc_pkg.sv
package dcc_pkg;
   typedef enum logic [2:0] {
      K_IDLE    = 3'd0,
      K_ACCESS  = 3'd1,
      K_MASKED  = 3'd2,
      K_XFER    = 3'd3,
      K_REFRESH = 3'd4,
      K_SPECIAL = 3'd5
   } cyc_kind_e;
endpackage

// File: rtl/dcc_edge.sv
// Registered fall detector for a vector of active-low strobes.
module dcc_edge #(
   parameter int W = 3
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] sig_n,
   output logic [W-1:0] fall
);
   logic [W-1:0] prev_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) prev_q <= '1;
      else        prev_q <= sig_n;
   end

   for (genvar i = 0; i < W; i++) begin : g_bit
      assign fall[i] = prev_q[i] & ~sig_n[i];
   end
endmodule

// File: rtl/dcc_decode.sv
// Chooses the cycle kind and latches the row at the row-strobe fall.
module dcc_decode
   import dcc_pkg::*;
#(
   parameter int A_W = 9
) (
   input  logic           clk,
   input  logic           rst_n,
   input  logic           ras_n,
   input  logic           ras_fall,
   input  logic           cas_n,
   input  logic           xoe_n,
   input  logic           wme_n,
   input  logic           fsel,
   input  logic [A_W-1:0] addr,
   output cyc_kind_e      kind,
   output logic [A_W-1:0] row,
   output logic           mask_load
);
   cyc_kind_e next_kind;

   always_comb begin
      if (!cas_n)      next_kind = K_REFRESH;
      else if (!xoe_n) next_kind = K_XFER;
      else if (!wme_n) next_kind = fsel ? K_SPECIAL : K_MASKED;
      else             next_kind = K_ACCESS;
   end

   assign mask_load = ras_fall && (next_kind == K_MASKED);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         kind <= K_IDLE;
         row  <= '0;
      end else if (ras_n) begin
         kind <= K_IDLE;
      end else if (ras_fall) begin
         kind <= next_kind;
         row  <= addr;
      end
   end
endmodule

// File: rtl/dcc_maskwr.sv
// Column latch, early/late write pulse generation, write mask and read enable.
module dcc_maskwr
   import dcc_pkg::*;
#(
   parameter int A_W           = 9,
   parameter int D_W           = 4,
   parameter bit LATE_WRITE_EN = 1'b1
) (
   input  logic           clk,
   input  logic           rst_n,
   input  logic           ras_n,
   input  logic           cas_n,
   input  logic           cas_fall,
   input  logic           wme_n,
   input  logic           wme_fall,
   input  logic           xoe_n,
   input  cyc_kind_e      kind,
   input  logic           mask_load,
   input  logic [A_W-1:0] addr,
   input  logic [D_W-1:0] dq_in,
   output logic [A_W-1:0] col,
   output logic [D_W-1:0] mask_q,
   output logic           mem_we,
   output logic [D_W-1:0] mem_wbe,
   output logic [D_W-1:0] mem_wdata,
   output logic           late_wr,
   output logic           dq_oe
);
   logic kind_wr, cas_start, cas_act, wrote, early, late, wr_now;

   assign kind_wr   = (kind == K_ACCESS) || (kind == K_MASKED);
   assign cas_start = kind_wr && !ras_n && cas_fall;
   assign early     = cas_start && !wme_n;

   if (LATE_WRITE_EN) begin : g_late
      assign late = cas_act && !cas_n && !ras_n && wme_fall && !wrote;
   end else begin : g_no_late
      assign late = 1'b0;
   end

   assign wr_now = early || late;

   for (genvar i = 0; i < D_W; i++) begin : g_wbe
      assign mem_wbe[i] = (kind == K_MASKED) ? mask_q[i] : 1'b1;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         mask_q    <= '0;
         col       <= '0;
         cas_act   <= 1'b0;
         wrote     <= 1'b0;
         mem_we    <= 1'b0;
         mem_wdata <= '0;
         late_wr   <= 1'b0;
         dq_oe     <= 1'b0;
      end else begin
         if (ras_n)          mask_q <= '0;
         else if (mask_load) mask_q <= dq_in;

         if (cas_start) col <= addr;

         if (ras_n || cas_n)  cas_act <= 1'b0;
         else if (cas_start)  cas_act <= 1'b1;

         if (ras_n || cas_n)  wrote <= 1'b0;
         else if (wr_now)     wrote <= 1'b1;

         mem_we <= wr_now;
         if (wr_now) begin
            mem_wdata <= dq_in;
            late_wr   <= late;
         end

         dq_oe <= !ras_n && !cas_n && !xoe_n && (cas_start || cas_act)
                  && !wr_now && !wrote;
      end
   end
endmodule

// File: rtl/dram_cycle_ctl.sv
module dram_cycle_ctl
   import dcc_pkg::*;
#(
   parameter int A_W           = 9,
   parameter int D_W           = 4,
   parameter bit LATE_WRITE_EN = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             ras_n,
   input  logic             cas_n,
   input  logic             xoe_n,
   input  logic             wme_n,
   input  logic             fsel,
   input  logic [A_W-1:0]   addr,
   input  logic [D_W-1:0]   dq_in,
   input  logic [D_W-1:0]   mem_rdata,
   output logic [2:0]       cyc_kind,
   output logic [2*A_W-1:0] word_addr,
   output logic [D_W-1:0]   mask_q,
   output logic             mem_we,
   output logic [D_W-1:0]   mem_wbe,
   output logic [D_W-1:0]   mem_wdata,
   output logic             late_wr,
   output logic             dq_oe,
   output logic [D_W-1:0]   dq_out
);
   localparam int WA_W = 2 * A_W;

   if (A_W < 1 || A_W > 16) begin : g_bad_aw
      $error("dram_cycle_ctl: A_W must be 1..16");
   end
   if (D_W < 1 || D_W > 32) begin : g_bad_dw
      $error("dram_cycle_ctl: D_W must be 1..32");
   end

   logic [2:0]     falls;
   cyc_kind_e      kind;
   logic [A_W-1:0] row, col;
   logic           mask_load;

   dcc_edge #(.W(3)) u_edge (
      .clk   (clk),
      .rst_n (rst_n),
      .sig_n ({wme_n, cas_n, ras_n}),
      .fall  (falls)
   );

   dcc_decode #(.A_W(A_W)) u_dec (
      .clk       (clk),
      .rst_n     (rst_n),
      .ras_n     (ras_n),
      .ras_fall  (falls[0]),
      .cas_n     (cas_n),
      .xoe_n     (xoe_n),
      .wme_n     (wme_n),
      .fsel      (fsel),
      .addr      (addr),
      .kind      (kind),
      .row       (row),
      .mask_load (mask_load)
   );

   dcc_maskwr #(.A_W(A_W), .D_W(D_W), .LATE_WRITE_EN(LATE_WRITE_EN)) u_mw (
      .clk       (clk),
      .rst_n     (rst_n),
      .ras_n     (ras_n),
      .cas_n     (cas_n),
      .cas_fall  (falls[1]),
      .wme_n     (wme_n),
      .wme_fall  (falls[2]),
      .xoe_n     (xoe_n),
      .kind      (kind),
      .mask_load (mask_load),
      .addr      (addr),
      .dq_in     (dq_in),
      .col       (col),
      .mask_q    (mask_q),
      .mem_we    (mem_we),
      .mem_wbe   (mem_wbe),
      .mem_wdata (mem_wdata),
      .late_wr   (late_wr),
      .dq_oe     (dq_oe)
   );

   assign cyc_kind  = kind;
   assign word_addr = WA_W'({row, col});
   assign dq_out    = dq_oe ? mem_rdata : '0;
endmodule

// File: rtl/dcc_check.sv
module dcc_check
   import dcc_pkg::*;
#(
   parameter int D_W = 4
) (
   input logic           clk,
   input logic           rst_n,
   input logic [2:0]     kind,
   input logic [D_W-1:0] mask_q,
   input logic           mem_we,
   input logic [D_W-1:0] mem_wbe,
   input logic           dq_oe
);
   // R9 / R10: a write strobe never lasts two clocks
   a_r9_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
      mem_we |=> !mem_we);

   // R12: writes only inside access or masked cycles
   a_r12_write_kind: assert property (@(posedge clk) disable iff (!rst_n)
      mem_we |-> (kind == K_ACCESS || kind == K_MASKED));

   // R12 / R11: read enable only inside access or masked cycles
   a_r11_oe_kind: assert property (@(posedge clk) disable iff (!rst_n)
      dq_oe |-> (kind == K_ACCESS || kind == K_MASKED));

   // R6: unmasked access writes every bit
   a_r6_full_enable: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_we && kind == K_ACCESS) |-> (mem_wbe == '1));

   // R7: outside a masked cycle the mask register is empty
   a_r7_mask_clear: assert property (@(posedge clk) disable iff (!rst_n)
      (kind != K_MASKED) |-> (mask_q == '0));

   // R8: mask does not change while one masked cycle lasts
   a_r8_mask_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (kind == K_MASKED && $past(kind) == K_MASKED) |-> $stable(mask_q));

   // R2: an idle port is quiet
   a_r2_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
      (kind == K_IDLE) |-> (!mem_we && !dq_oe));
endmodule

bind dram_cycle_ctl dcc_check #(.D_W(D_W)) u_chk (
   .clk     (clk),
   .rst_n   (rst_n),
   .kind    (cyc_kind),
   .mask_q  (mask_q),
   .mem_we  (mem_we),
   .mem_wbe (mem_wbe),
   .dq_oe   (dq_oe)
);

// File: tb/sim_dram_cycle_ctl.sv
`timescale 1ns/1ps
module sim_dram_cycle_ctl;
   localparam int A_W = 9;
   localparam int D_W = 4;

   logic clk = 1'b0, rst_n = 1'b0;
   logic ras_n = 1, cas_n = 1, xoe_n = 1, wme_n = 1, fsel = 0;
   logic [A_W-1:0]   addr = '0;
   logic [D_W-1:0]   dq_in = '0, mem_rdata;
   logic [2:0]       cyc_kind;
   logic [2*A_W-1:0] word_addr;
   logic [D_W-1:0]   mask_q, mem_wbe, mem_wdata, dq_out;
   logic             mem_we, late_wr, dq_oe;

   int n_chk = 0, n_fail = 0, cyc = 0, upd = 0;
   logic [D_W-1:0] arr [int];   // behavioural storage driven by the DUT
   logic [D_W-1:0] expm [int];  // bench expectation

   always #2 clk = ~clk;

   dram_cycle_ctl #(.A_W(A_W), .D_W(D_W)) u0 (
      .clk(clk), .rst_n(rst_n), .ras_n(ras_n), .cas_n(cas_n), .xoe_n(xoe_n),
      .wme_n(wme_n), .fsel(fsel), .addr(addr), .dq_in(dq_in),
      .mem_rdata(mem_rdata), .cyc_kind(cyc_kind), .word_addr(word_addr),
      .mask_q(mask_q), .mem_we(mem_we), .mem_wbe(mem_wbe),
      .mem_wdata(mem_wdata), .late_wr(late_wr), .dq_oe(dq_oe), .dq_out(dq_out)
   );

   function automatic logic [D_W-1:0] get_arr(int a);
      return arr.exists(a) ? arr[a] : '0;
   endfunction
   function automatic logic [D_W-1:0] get_exp(int a);
      return expm.exists(a) ? expm[a] : '0;
   endfunction
   function automatic logic [D_W-1:0] merge(logic [D_W-1:0] old, logic [D_W-1:0] d,
                                            logic [D_W-1:0] en);
      return (old & ~en) | (d & en);
   endfunction

   always @(negedge clk) begin
      if (mem_we) begin
         arr[int'(word_addr)] = merge(get_arr(int'(word_addr)), mem_wdata, mem_wbe);
         upd++;
      end
   end
   always @(word_addr or upd) mem_rdata = get_arr(int'(word_addr));

   always @(posedge clk) begin
      cyc++;
      if (cyc > 150000) begin
         n_chk++; n_fail++;
         $display("FAIL watchdog (all requirements): actual still running, expected done");
         $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
         $finish;
      end
   end

   task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual %0h expected %0h", req, act, exp);
      end
   endtask

   task automatic tick();
      @(negedge clk);
   endtask

   // kinds: 1 access, 2 masked, 3 transfer, 4 refresh, 5 special
   task automatic ras_open(int k, logic [A_W-1:0] row, logic [D_W-1:0] mk);
      addr = row; dq_in = mk;
      xoe_n = (k == 3) ? 1'b0 : 1'b1;
      wme_n = (k == 2 || k == 5) ? 1'b0 : 1'b1;
      fsel  = (k == 5);
      if (k == 4) begin cas_n = 0; tick(); end
      ras_n = 0;
      tick();
      chk("R3 kind", cyc_kind, k);
      chk("R4 row", word_addr[2*A_W-1:A_W], row);
      chk("R5 mask", mask_q, (k == 2) ? mk : '0);
      wme_n = 1; xoe_n = 1; fsel = 0; dq_in = ~mk;
   endtask

   task automatic ras_close();
      ras_n = 1; cas_n = 1; wme_n = 1; xoe_n = 1;
      tick();
      chk("R3 idle after close", cyc_kind, 0);
      chk("R7 mask cleared", mask_q, 0);
   endtask

   task automatic cas_write(logic [A_W-1:0] row, logic [A_W-1:0] col, logic [D_W-1:0] d,
                            bit late_mode, logic [D_W-1:0] en);
      int a;
      a = int'({row, col});
      addr = col; dq_in = d;
      if (late_mode) begin
         wme_n = 1; cas_n = 0; tick();
         chk("R10 no write before WE falls", mem_we, 0);
         dq_in = d; wme_n = 0; tick();
         chk("R10 late pulse", mem_we, 1);
         chk("R10 late flag", late_wr, 1);
      end else begin
         wme_n = 0; cas_n = 0; tick();
         chk("R9 early pulse", mem_we, 1);
         chk("R9 early flag", late_wr, 0);
      end
      chk("R4 write address", word_addr, a);
      chk("R9 write data", mem_wdata, d);
      chk("R6 bit enables", mem_wbe, en);
      expm[a] = merge(get_exp(a), d, en);
      dq_in = ~d; tick();
      chk("R10 single write per column", mem_we, 0);
      cas_n = 1; wme_n = 1; tick();
   endtask

   task automatic cas_read(logic [A_W-1:0] row, logic [A_W-1:0] col);
      int a;
      a = int'({row, col});
      addr = col; wme_n = 1; cas_n = 0; xoe_n = 0; tick();
      chk("R11 output enabled", dq_oe, 1);
      chk("R11 read data", dq_out, get_exp(a));
      cas_n = 1; xoe_n = 1; tick();
      chk("R11 output released", dq_oe, 0);
      chk("R11 data idle", dq_out, 0);
   endtask

   task automatic cas_nowrite(logic [A_W-1:0] col);
      addr = col; dq_in = 4'hF; cas_n = 0; wme_n = 0; xoe_n = 0; tick();
      chk("R12 no write", mem_we, 0);
      chk("R12 no drive", dq_oe, 0);
      wme_n = 1; tick(); wme_n = 0; tick();
      chk("R12 no late write", mem_we, 0);
      cas_n = 1; wme_n = 1; xoe_n = 1; tick();
   endtask

   initial begin
      int seed;
      seed = $urandom(32'd20240611);
      tick(); tick();
      chk("R1 reset kind", cyc_kind, 0);
      chk("R1 reset we", mem_we, 0);
      chk("R1 reset oe", dq_oe, 0);
      chk("R1 reset mask", mask_q, 0);
      rst_n = 1; tick();

      // R2: strobes and data wiggle with the row strobe high
      for (int i = 0; i < 24; i++) begin
         cas_n = 1'($urandom); wme_n = 1'($urandom); xoe_n = 1'($urandom);
         fsel = 1'($urandom); addr = A_W'($urandom); dq_in = D_W'($urandom);
         tick();
         chk("R2 kind idle", cyc_kind, 0);
         chk("R2 no write", mem_we, 0);
         chk("R2 no drive", dq_oe, 0);
      end
      cas_n = 1; wme_n = 1; xoe_n = 1; fsel = 0; tick();

      // R9, R10, R11: access cycle, early then late write, then reads
      ras_open(1, 9'd3, 4'h0);
      cas_write(9'd3, 9'd5, 4'hA, 0, 4'hF);
      cas_write(9'd3, 9'd6, 4'h5, 1, 4'hF);
      cas_read(9'd3, 9'd5);
      cas_read(9'd3, 9'd6);
      ras_close();

      // R5, R6, R8: masked page-mode writes share one mask
      ras_open(2, 9'd3, 4'b0101);
      cas_write(9'd3, 9'd5, 4'hF, 0, 4'b0101);
      cas_write(9'd3, 9'd6, 4'h0, 1, 4'b0101);
      chk("R8 mask held", mask_q, 4'b0101);
      cas_read(9'd3, 9'd5);
      ras_close();
      // R7: next masked cycle takes a fresh mask
      ras_open(2, 9'd3, 4'b1000);
      cas_write(9'd3, 9'd6, 4'hF, 0, 4'b1000);
      cas_read(9'd3, 9'd6);
      ras_close();

      // R12 / R3: non-access kinds
      ras_open(3, 9'd1, 4'h0); cas_nowrite(9'd2); ras_close();
      ras_open(5, 9'd1, 4'h0); cas_nowrite(9'd2); ras_close();
      ras_open(4, 9'd1, 4'h0);
      wme_n = 0; xoe_n = 0; tick();
      chk("R12 refresh no write", mem_we, 0);
      chk("R12 refresh no drive", dq_oe, 0);
      ras_close();

      // random mix over a small address window
      for (int r = 0; r < 60; r++) begin
         int sel, k, ncas;
         logic [A_W-1:0] row;
         logic [D_W-1:0] mk;
         sel = int'($urandom % 10);
         k = (sel == 0) ? 4 : (sel == 1) ? 3 : (sel == 2) ? 5 : (sel < 6) ? 2 : 1;
         row = A_W'($urandom % 4);
         mk = D_W'($urandom);
         ras_open(k, row, mk);
         ncas = 1 + int'($urandom % 3);
         for (int c = 0; c < ncas; c++) begin
            logic [A_W-1:0] col;
            int op;
            col = A_W'($urandom % 8);
            op = int'($urandom % 3);
            if (k >= 3) cas_nowrite(col);
            else if (op == 2) cas_read(row, col);
            else cas_write(row, col, D_W'($urandom), op == 1,
                           (k == 2) ? mk : '1);
         end
         if (k == 2) chk("R8 mask after page", mask_q, mk);
         ras_close();
      end

      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
   end
endmodule